// File: doc/BRIEF.md
# Dual-Slot SD Host Register Wrapper

This block is the register front end that sits between a 32-bit memory-mapped bus and two SD host slot controllers. It decodes a 4 KB window into three regions. The lowest 256 bytes hold a small bank of global registers. The next two 256-byte sub-windows carry accesses through to the register ports of slot 0 and slot 1. Any access above those regions is refused.

The global bank keeps an identification word and a debounce setting, both with fixed non-zero reset values. It also holds plain storage words for bus control, write-protect polarity and card detect. Each slot has a capability word and a maximum-current word. The wrapper holds both words, drives them to the slot, and makes them readable and writable at global offsets.

The two slot interrupt lines are sampled and edge-detected. The result feeds a read-only status word and one combined interrupt output. A falling line always lowers the combined output, even while the other line is still high. Every read completes one cycle after the request, whichever region it targets.

Top module: `sd_dual_host_regs`

## Requirements
- R1: After reset, offset 0x000 reads 0x00030000 and offset 0x004 reads 0x00000005. Offsets 0x008, 0x0EC, 0x0F0, 0x0FC, 0x010, 0x018, 0x020 and 0x028 read 0. The outputs irq_out, bus_rvalid and bus_err are low.
- R2: A read request (bus_req=1, bus_we=0) produces bus_rvalid=1 and its bus_rdata on the cycle after the request, and bus_rvalid is low otherwise.
- R3: Offsets 0x000, 0x004, 0x008, 0x0EC and 0x0F0 are 32-bit read/write storage, and a write is returned by the next read of that offset.
- R4: Offset 0x010 holds the slot 0 capability word and offset 0x018 the slot 0 maximum-current word. Offsets 0x020 and 0x028 hold the same two words for slot 1. Each word reads back, and it is driven on slot_cap[32n+31:32n] or slot_maxcur[32n+31:32n] from the cycle after the write.
- R5: An access whose address bits [11:8] equal n+1 (slot 0 at 0x100..0x1FF, slot 1 at 0x200..0x2FF) raises slot_req[n] in the same cycle. In that cycle slot_addr equals address bits [7:0], and slot_we and slot_wdata follow the bus. A read returns slot_rdata[32n+31:32n] one cycle later.
- R6: When slot line n rises, status bit n (offset 0x0FC, bit n) is set and irq_out goes high one clock edge after the new level is sampled.
- R7: When slot line n falls, status bit n clears and irq_out goes low one edge later, even if the other line is high. If one line falls in the same cycle that another rises, irq_out goes low.
- R8: A line held at a constant level changes neither the status nor irq_out, so irq_out stays low while a line that was already high stays high.
- R9: An access at address 0x300 or above changes no register, reads as 0, and pulses bus_err for exactly one cycle, the cycle after the request.
- R10: An access with bus_word=0 is refused. It writes nothing, raises no slot_req, reads as 0 and pulses bus_err the cycle after.
- R11: Global offsets below 0x100 that name no register read as 0, ignore writes and raise no bus_err.
- R12: The status word at 0x0FC is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access; 0 = narrower access (refused) |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | One-cycle pulse for a refused access |
| slot_req | output | 2 | Per-slot access select |
| slot_we | output | 1 | Write flag towards the slots |
| slot_addr | output | 8 | Offset inside the slot sub-window |
| slot_wdata | output | 32 | Write data towards the slots |
| slot_rdata | input | 64 | Per-slot read data, slot n in bits [32n+31:32n] |
| slot_irq | input | 2 | Per-slot interrupt line |
| slot_cap | output | 64 | Capability word held for each slot |
| slot_maxcur | output | 64 | Maximum-current word held for each slot |
| irq_out | output | 1 | Combined interrupt |

## Verification
A corrupted sampled line level in the interrupt merger produces a spurious or missing edge. That shows up on irq_out and in the status word on the very next clock edge. In the held-level case, where irq_out must stay low while slot 1 stays high, a false rise appears within one cycle. A wrong decode or a wrongly held register shows up on the next read of that offset, one cycle after the request, or on slot_req during the request cycle. The alias words appear on slot_cap and slot_maxcur one edge after the write.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned WIN_AW   = 12;   // 4 KB window
  localparam int unsigned SUB_AW   = 8;    // 256-byte regions
  localparam int unsigned REGION_W = WIN_AW - SUB_AW;

  // global bank offsets
  localparam logic [SUB_AW-1:0] OFF_IDENT  = 8'h00;
  localparam logic [SUB_AW-1:0] OFF_DBNC   = 8'h04;
  localparam logic [SUB_AW-1:0] OFF_BUSCTL = 8'h08;
  localparam logic [SUB_AW-1:0] OFF_WPPOL  = 8'hEC;
  localparam logic [SUB_AW-1:0] OFF_CDET   = 8'hF0;
  localparam logic [SUB_AW-1:0] OFF_ISTAT  = 8'hFC;

  // per-slot alias words: base + n*step, max-current at +8
  localparam int unsigned ALIAS_BASE = 'h10;
  localparam int unsigned ALIAS_STEP = 'h10;
  localparam int unsigned ALIAS_MC   = 'h08;

  localparam logic [WORD_W-1:0] IDENT_RST = 32'h0003_0000;
  localparam logic [WORD_W-1:0] DBNC_RST  = 32'h0000_0005;

  function automatic logic [SUB_AW-1:0] cap_off(input int unsigned n);
    return SUB_AW'(ALIAS_BASE + n * ALIAS_STEP);
  endfunction

  function automatic logic [SUB_AW-1:0] mc_off(input int unsigned n);
    return SUB_AW'(ALIAS_BASE + n * ALIAS_STEP + ALIAS_MC);
  endfunction

endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
  import sdw_pkg::*;
#(
  parameter int unsigned NSLOT = 2
) (
  input  logic                req,
  input  logic                word,
  input  logic [REGION_W-1:0] region,
  output logic                glob_hit,
  output logic [NSLOT-1:0]    slot_hit,
  output logic                refuse
);

  localparam logic [REGION_W-1:0] LAST_REGION = REGION_W'(NSLOT);

  logic ok;
  assign ok       = req && word;
  assign glob_hit = ok && (region == '0);
  assign refuse   = req && (!word || (region > LAST_REGION));

  for (genvar n = 0; n < NSLOT; n++) begin : g_hit
    assign slot_hit[n] = ok && (region == REGION_W'(n + 1));
  end

endmodule

// File: rtl/sdw_irq_merge.sv
module sdw_irq_merge #(
  parameter int unsigned NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] line,
  output logic [NSLOT-1:0] stat,
  output logic             irq
);

  logic [NSLOT-1:0] prev_q, stat_q, stat_d, rise, fall;
  logic             irq_q, irq_d;

  always_comb begin
    rise   = line & ~prev_q;
    fall   = ~line & prev_q;
    stat_d = (stat_q | rise) & ~fall;
    irq_d  = irq_q;
    if (|fall) begin
      irq_d = 1'b0;            // any drop lowers the merged line
    end else if (|rise) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= line;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;

endmodule

// File: rtl/sdw_gregs.sv
module sdw_gregs
  import sdw_pkg::*;
#(
  parameter int unsigned        NSLOT      = 2,
  parameter logic [WORD_W-1:0]  CAP_RST    = '0,
  parameter logic [WORD_W-1:0]  MAXCUR_RST = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SUB_AW-1:0]       off,
  input  logic [WORD_W-1:0]       wdata,
  input  logic [NSLOT-1:0]        istat,
  output logic [WORD_W-1:0]       rd_val,
  output logic [NSLOT*WORD_W-1:0] cap,
  output logic [NSLOT*WORD_W-1:0] maxcur
);

  logic [WORD_W-1:0] ident_q, dbnc_q, busctl_q, wppol_q, cdet_q;
  logic [WORD_W-1:0] ident_d, dbnc_d, busctl_d, wppol_d, cdet_d;

  always_comb begin
    ident_d  = ident_q;
    dbnc_d   = dbnc_q;
    busctl_d = busctl_q;
    wppol_d  = wppol_q;
    cdet_d   = cdet_q;
    if (wr_en) begin
      unique case (off)
        OFF_IDENT:  ident_d  = wdata;
        OFF_DBNC:   dbnc_d   = wdata;
        OFF_BUSCTL: busctl_d = wdata;
        OFF_WPPOL:  wppol_d  = wdata;
        OFF_CDET:   cdet_d   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q  <= IDENT_RST;
      dbnc_q   <= DBNC_RST;
      busctl_q <= '0;
      wppol_q  <= '0;
      cdet_q   <= '0;
    end else begin
      ident_q  <= ident_d;
      dbnc_q   <= dbnc_d;
      busctl_q <= busctl_d;
      wppol_q  <= wppol_d;
      cdet_q   <= cdet_d;
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_alias
    logic [WORD_W-1:0] cap_q, cap_d, mc_q, mc_d;
    logic              cap_we, mc_we;

    assign cap_we = wr_en && (off == cap_off(n));
    assign mc_we  = wr_en && (off == mc_off(n));

    always_comb begin
      cap_d = cap_we ? wdata : cap_q;
      mc_d  = mc_we  ? wdata : mc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q <= CAP_RST;
        mc_q  <= MAXCUR_RST;
      end else begin
        cap_q <= cap_d;
        mc_q  <= mc_d;
      end
    end

    assign cap[n*WORD_W +: WORD_W]    = cap_q;
    assign maxcur[n*WORD_W +: WORD_W] = mc_q;
  end

  always_comb begin
    rd_val = '0;
    unique case (off)
      OFF_IDENT:  rd_val = ident_q;
      OFF_DBNC:   rd_val = dbnc_q;
      OFF_BUSCTL: rd_val = busctl_q;
      OFF_WPPOL:  rd_val = wppol_q;
      OFF_CDET:   rd_val = cdet_q;
      OFF_ISTAT:  rd_val = WORD_W'(istat);
      default: ;
    endcase
    for (int n = 0; n < NSLOT; n++) begin
      if (off == cap_off(n)) rd_val = cap[n*WORD_W +: WORD_W];
      if (off == mc_off(n))  rd_val = maxcur[n*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/sd_dual_host_regs.sv
module sd_dual_host_regs
  import sdw_pkg::*;
#(
  parameter int unsigned        NSLOT      = 2,
  parameter logic [WORD_W-1:0]  CAP_RST    = '0,
  parameter logic [WORD_W-1:0]  MAXCUR_RST = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic                    bus_word,
  input  logic [WIN_AW-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic                    bus_rvalid,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    bus_err,
  output logic [NSLOT-1:0]        slot_req,
  output logic                    slot_we,
  output logic [SUB_AW-1:0]       slot_addr,
  output logic [WORD_W-1:0]       slot_wdata,
  input  logic [NSLOT*WORD_W-1:0] slot_rdata,
  input  logic [NSLOT-1:0]        slot_irq,
  output logic [NSLOT*WORD_W-1:0] slot_cap,
  output logic [NSLOT*WORD_W-1:0] slot_maxcur,
  output logic                    irq_out
);

  logic              glob_hit, refuse;
  logic [NSLOT-1:0]  slot_hit, istat;
  logic [WORD_W-1:0] greg_rd;

  sdw_decode #(.NSLOT(NSLOT)) u_dec (
    .req      (bus_req),
    .word     (bus_word),
    .region   (bus_addr[WIN_AW-1:SUB_AW]),
    .glob_hit (glob_hit),
    .slot_hit (slot_hit),
    .refuse   (refuse)
  );

  sdw_gregs #(.NSLOT(NSLOT), .CAP_RST(CAP_RST), .MAXCUR_RST(MAXCUR_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (glob_hit && bus_we),
    .off    (bus_addr[SUB_AW-1:0]),
    .wdata  (bus_wdata),
    .istat  (istat),
    .rd_val (greg_rd),
    .cap    (slot_cap),
    .maxcur (slot_maxcur)
  );

  sdw_irq_merge #(.NSLOT(NSLOT)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .line  (slot_irq),
    .stat  (istat),
    .irq   (irq_out)
  );

  // slot pass-through, same cycle as the bus request
  assign slot_req   = slot_hit;
  assign slot_we    = bus_we;
  assign slot_addr  = bus_addr[SUB_AW-1:0];
  assign slot_wdata = bus_wdata;

  // read return path: one register stage
  logic              rv_q, rv_d, err_q, err_d;
  logic [WORD_W-1:0] rd_q, rd_d;

  always_comb begin
    rv_d  = bus_req && !bus_we;
    err_d = refuse;
    rd_d  = '0;
    if (rv_d) begin
      if (glob_hit) rd_d = greg_rd;
      for (int n = 0; n < NSLOT; n++) begin
        if (slot_hit[n]) rd_d = slot_rdata[n*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rv_q  <= rv_d;
      err_q <= err_d;
      if (rv_d) rd_q <= rd_d;   // clock enable: hold data between reads
    end
  end

  assign bus_rvalid = rv_q;
  assign bus_err    = err_q;
  assign bus_rdata  = rv_q ? rd_q : '0;

endmodule

// File: rtl/sd_dual_host_regs_chk.sv
module sd_dual_host_regs_chk #(
  parameter int unsigned NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic             bus_word,
  input logic [3:0]       region,
  input logic             bus_rvalid,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic [NSLOT-1:0] slot_req,
  input logic [NSLOT-1:0] slot_irq,
  input logic             irq_out
);

  // R2: read data returns exactly one cycle after a read request
  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  p_rvalid_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

  // R9: error pulse only follows a request, refused reads return zero
  p_err_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_req));
  p_err_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_rvalid) |-> (bus_rdata == 32'h0));

  // R10: narrow accesses never reach a slot
  p_narrow_no_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_word) |-> (slot_req == '0));

  // R5: at most one slot selected
  p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_req));

  for (genvar n = 0; n < NSLOT; n++) begin : g_chk
    // R5: a slot select matches its sub-window
    p_slot_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_req[n] |-> (region == 4'(n + 1)));
    // R6: a rise with no simultaneous fall raises the merged line
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(slot_irq[n]) && !$fell(slot_irq[NSLOT-1-n])) |=> irq_out);
    // R7: any fall lowers the merged line
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slot_irq[n]) |=> !irq_out);
  end

  // R8: with all lines steady the merged line holds
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(slot_irq) && $stable(irq_out)) |=> $stable(irq_out));

endmodule

bind sd_dual_host_regs sd_dual_host_regs_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_word   (bus_word),
  .region     (bus_addr[11:8]),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .slot_req   (slot_req),
  .slot_irq   (slot_irq),
  .irq_out    (irq_out)
);

// File: tb/sim_sd_dual_host_regs.sv
`timescale 1ns/1ps
module sim_sd_dual_host_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid, bus_err, slot_we, irq_out;
  logic [31:0] bus_rdata, slot_wdata;
  logic [1:0]  slot_req;
  logic [7:0]  slot_addr;
  logic [63:0] slot_rdata, slot_cap, slot_maxcur;
  logic [1:0]  slot_irq = 2'b00;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  // slot register model: slot n returns {A0+n, 0000, offset}
  always_comb begin
    for (int n = 0; n < 2; n++) slot_rdata[n*32 +: 32] = {8'hA0 + 8'(n), 16'h0, slot_addr};
  end

  sd_dual_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .slot_req(slot_req), .slot_we(slot_we),
    .slot_addr(slot_addr), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
    .slot_irq(slot_irq), .slot_cap(slot_cap), .slot_maxcur(slot_maxcur), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic        rv, er, s_we;
  logic [1:0]  s_req;
  logic [7:0]  s_addr;
  logic [31:0] s_wd;

  task automatic access(input logic we, input logic word, input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = wd;
    #1;
    s_req = slot_req; s_addr = slot_addr; s_wd = slot_wdata; s_we = slot_we;
    @(posedge clk);
    @(negedge clk);
    rd = bus_rdata; rv = bus_rvalid; er = bus_err;
    bus_req = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
  endtask

  task automatic set_irq(input logic [1:0] v);
    @(negedge clk);
    slot_irq = v;
    @(negedge clk);   // one edge has sampled the new level
  endtask

  typedef struct packed {
    logic        we;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'h0,         32'h0003_0000, 4'd1},  // R1
    '{1'b0, 12'h004, 32'h0,         32'h0000_0005, 4'd1},  // R1
    '{1'b0, 12'h008, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b0, 12'h0EC, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b0, 12'h0F0, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b0, 12'h0FC, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b0, 12'h010, 32'h0,         32'h0,         4'd1},  // R1
    '{1'b1, 12'h008, 32'hA5A5_0008, 32'h0,         4'd3},  // R3
    '{1'b0, 12'h008, 32'h0,         32'hA5A5_0008, 4'd3},  // R3
    '{1'b1, 12'h0EC, 32'h0000_0003, 32'h0,         4'd3},  // R3
    '{1'b0, 12'h0EC, 32'h0,         32'h0000_0003, 4'd3},  // R3
    '{1'b1, 12'h0F0, 32'hF0F0_1234, 32'h0,         4'd3},  // R3
    '{1'b0, 12'h0F0, 32'h0,         32'hF0F0_1234, 4'd3},  // R3
    '{1'b1, 12'h004, 32'h0000_0010, 32'h0,         4'd3},  // R3
    '{1'b0, 12'h004, 32'h0,         32'h0000_0010, 4'd3},  // R3
    '{1'b1, 12'h010, 32'hCAFE_0010, 32'h0,         4'd4},  // R4
    '{1'b1, 12'h018, 32'hBEEF_0018, 32'h0,         4'd4},  // R4
    '{1'b1, 12'h020, 32'hCAFE_0020, 32'h0,         4'd4},  // R4
    '{1'b1, 12'h028, 32'hBEEF_0028, 32'h0,         4'd4},  // R4
    '{1'b0, 12'h010, 32'h0,         32'hCAFE_0010, 4'd4},  // R4
    '{1'b0, 12'h018, 32'h0,         32'hBEEF_0018, 4'd4},  // R4
    '{1'b0, 12'h020, 32'h0,         32'hCAFE_0020, 4'd4},  // R4
    '{1'b0, 12'h028, 32'h0,         32'hBEEF_0028, 4'd4},  // R4
    '{1'b1, 12'h034, 32'hDEAD_BEEF, 32'h0,         4'd11}, // R11
    '{1'b0, 12'h034, 32'h0,         32'h0,         4'd11}, // R11
    '{1'b1, 12'h0FC, 32'hFFFF_FFFF, 32'h0,         4'd12}, // R12
    '{1'b0, 12'h0FC, 32'h0,         32'h0,         4'd12}, // R12
    '{1'b1, 12'h308, 32'h1111_1111, 32'h0,         4'd9},  // R9
    '{1'b0, 12'h008, 32'h0,         32'hA5A5_0008, 4'd9},  // R9
    '{1'b0, 12'h308, 32'h0,         32'h0,         4'd9}   // R9
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_out == 1'b0 && bus_rvalid == 1'b0 && bus_err == 1'b0, "R1 reset outputs",
        {bus_err, bus_rvalid, irq_out}, 0);

    // vector walk: R1 R3 R4 R9 R11 R12 data, R2 valid timing, error flag
    for (int i = 0; i < NV; i++) begin
      logic exp_err;
      access(VEC[i].we, 1'b1, VEC[i].a, VEC[i].d);
      exp_err = (VEC[i].a >= 12'h300);
      if (!VEC[i].we) begin
        chk(rd == VEC[i].exp, $sformatf("R%0d vec %0d read", VEC[i].req, i), rd, VEC[i].exp);
        chk(rv == 1'b1, $sformatf("R2 vec %0d rvalid", i), rv, 1);
      end else begin
        chk(rv == 1'b0, $sformatf("R2 vec %0d no rvalid on write", i), rv, 0);
      end
      chk(er == exp_err, $sformatf("R%0d vec %0d err flag", VEC[i].req, i), er, exp_err);
    end

    // R4: alias words driven towards the slots
    chk(slot_cap == 64'hCAFE_0020_CAFE_0010, "R4 slot_cap", slot_cap, 64'hCAFE_0020_CAFE_0010);
    chk(slot_maxcur == 64'hBEEF_0028_BEEF_0018, "R4 slot_maxcur", slot_maxcur, 64'hBEEF_0028_BEEF_0018);

    // R5: slot sub-window pass-through
    access(1'b1, 1'b1, 12'h104, 32'h1122_3344);
    chk(s_req == 2'b01 && s_addr == 8'h04 && s_we == 1'b1 && s_wd == 32'h1122_3344,
        "R5 slot0 write", {s_req, s_addr, s_wd}, {2'b01, 8'h04, 32'h1122_3344});
    access(1'b0, 1'b1, 12'h2A8, 32'h0);
    chk(s_req == 2'b10, "R5 slot1 select", s_req, 2'b10);
    chk(rd == 32'hA100_00A8 && rv, "R5 slot1 read", rd, 32'hA100_00A8);
    access(1'b0, 1'b1, 12'h1FC, 32'h0);
    chk(rd == 32'hA000_00FC, "R5 slot0 top read", rd, 32'hA000_00FC);

    // R10: narrow accesses refused
    access(1'b1, 1'b0, 12'h008, 32'h0BAD_0BAD);
    chk(er == 1'b1, "R10 narrow write err", er, 1);
    access(1'b0, 1'b1, 12'h008, 32'h0);
    chk(rd == 32'hA5A5_0008, "R10 narrow write ignored", rd, 32'hA5A5_0008);
    access(1'b0, 1'b0, 12'h104, 32'h0);
    chk(s_req == 2'b00 && rd == 32'h0 && er == 1'b1, "R10 narrow slot read",
        {s_req, rd, er}, {2'b00, 32'h0, 1'b1});

    // R9: far address, single-cycle error pulse
    access(1'b0, 1'b1, 12'hFFC, 32'h0);
    chk(er == 1'b1 && rd == 32'h0 && rv == 1'b1, "R9 far read", {er, rd}, {1'b1, 32'h0});
    @(negedge clk);
    chk(bus_err == 1'b0, "R9 err pulse one cycle", bus_err, 0);

    // R6 / R7 / R8 interrupt merging
    set_irq(2'b01);
    chk(irq_out == 1'b1, "R6 slot0 rise", irq_out, 1);
    access(1'b0, 1'b1, 12'h0FC, 32'h0);
    chk(rd == 32'h1, "R6 status slot0", rd, 1);
    set_irq(2'b11);
    chk(irq_out == 1'b1, "R6 both high", irq_out, 1);
    access(1'b0, 1'b1, 12'h0FC, 32'h0);
    chk(rd == 32'h3, "R6 status both", rd, 3);
    set_irq(2'b10);
    chk(irq_out == 1'b0, "R7 slot0 fall lowers output", irq_out, 0);
    repeat (5) @(negedge clk);
    chk(irq_out == 1'b0, "R8 held level no re-raise", irq_out, 0);
    access(1'b0, 1'b1, 12'h0FC, 32'h0);
    chk(rd == 32'h2, "R7 status after fall", rd, 2);
    set_irq(2'b00);
    access(1'b0, 1'b1, 12'h0FC, 32'h0);
    chk(rd == 32'h0 && irq_out == 1'b0, "R7 all low", {irq_out, rd}, 0);
    set_irq(2'b10);
    chk(irq_out == 1'b1, "R6 slot1 rise", irq_out, 1);
    set_irq(2'b01);
    chk(irq_out == 1'b0, "R7 fall beats rise", irq_out, 0);
    access(1'b0, 1'b1, 12'h0FC, 32'h0);
    chk(rd == 32'h1, "R7 status swap", rd, 1);
    set_irq(2'b11);
    chk(irq_out == 1'b1, "R6 rise after swap", irq_out, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule